// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block brings the supply domains of an RF front end up in a fixed order and takes them down again. It drives three rail enables (digital, RF front end and, in the extended build, the power amplifier). Between rail steps it issues single-cycle initialisation strobes to the clock generator, the transmit and receive synthesizers, a bank of beamformer devices and the amplifier bias setup. After each strobe it waits for an acknowledge on `init_done`. Every dwell is measured in milliseconds, and a restartable prescaler derives the millisecond from the clock.

A one-cycle `power_up` pulse starts the up-sequence from the off state. A one-cycle `power_down` pulse starts the down-sequence from any up step, including a partly completed one. The down-sequence removes the amplifier rail first and waits. It then drops the RF rail and, on the next cycle, the digital rail. The `stage` output reports progress as a small code, and `ready` and `off` flag the two resting states.

Top module: `rf_power_sequencer`

## Requirements
- R1: While reset is held and right after it, all rails are off, no strobe is high, `stage` is 0 and `off` is 1.
- R2: `stage` reports 0 for off, 1 for the digital step (including clock generator init), 2 for synthesizer steps, 3 for the RF rail step (including beamformer init and the final RF drop), 4 for amplifier steps (up and down) and 5 for ready.
- R3: A `power_up` pulse in the off state raises the digital rail on the next cycle. The rail then holds for DIG_MS*CLKS_PER_MS+1 cycles, after which the clock generator strobe fires.
- R4: Each init strobe is high for exactly one cycle, and at most one strobe is high at any time. The sequence advances only on an `init_done` seen in a cycle after the strobe. An `init_done` at any other time has no effect. The next dwell starts on the acknowledge.
- R5: After the clock generator acknowledge and a CLK_MS dwell, the transmit synthesizer is strobed, then the receive synthesizer, followed by a SYN_MS dwell.
- R6: The RF rail then rises with an RF_MS dwell. After that the beamformer strobe fires NUM_BF times, with `bf_sel` counting 0, 1, 2, 3 in that order, each strobe waiting for its own acknowledge.
- R7: With EXTENDED=1 the amplifier rail rises after the last beamformer acknowledge, holds for PA_MS, and then the bias strobe fires. With EXTENDED=0 the amplifier rail never rises.
- R8: `ready` (stage 5) is reached only after the final acknowledge. In ready, every rail of the build is on.
- R9: A `power_down` pulse in ready drops the amplifier rail first (extended build) and waits PA_DN_MS*CLKS_PER_MS+1 cycles. It then drops the RF rail for one cycle before the digital rail, and returns to off.
- R10: `power_up` outside the off state, and `power_down` in the off state or during the down-sequence, have no effect.
- R11: A `power_down` pulse during any up step abandons the up-sequence on the next cycle. The down-sequence begins with the amplifier step if that rail is on, and with the RF drop otherwise.
- R12: If `init_done` never arrives, the sequencer stays in the acknowledge wait indefinitely, keeping its rails and issuing no further strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| power_up | input | 1 | One-cycle request to start the up-sequence |
| power_down | input | 1 | One-cycle request to start the down-sequence |
| init_done | input | 1 | Acknowledge from the device just strobed |
| dig_rail_en | output | 1 | Digital rail enable |
| rf_rail_en | output | 1 | RF front-end rail enable |
| pa_rail_en | output | 1 | Amplifier rail enable (extended build only) |
| clkgen_init | output | 1 | Clock generator init strobe |
| synth_tx_init | output | 1 | Transmit synthesizer init strobe |
| synth_rx_init | output | 1 | Receive synthesizer init strobe |
| bf_init | output | 1 | Beamformer init strobe |
| bf_sel | output | BF_W | Index of the beamformer being initialised |
| pa_bias_init | output | 1 | Amplifier bias setup strobe |
| stage | output | 3 | Progress code as in R2 |
| ready | output | 1 | Up-sequence complete |
| off | output | 1 | Fully powered down |

## Verification
The hardest situations to reach are a `power_down` landing in a particular sub-step of a long sequence, for example while an acknowledge is pending in the synthesizer step or partway through the amplifier dwell. Equally hard is an acknowledge that arrives at the wrong moment. The stimulus reaches these by waiting on the `stage` output before pulsing the request, by injecting stray `init_done` pulses during dwells, and by switching the acknowledge responder off so that the block stalls. The responder is later released by hand. A short prescaler keeps every dwell to a few hundred cycles. Both builds run side by side on the same requests, each against its own queue-based model.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        STG_OFF     = 3'd0,
        STG_DIGITAL = 3'd1,
        STG_SYNTH   = 3'd2,
        STG_RF      = 3'd3,
        STG_PA      = 3'd4,
        STG_READY   = 3'd5
    } stage_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_DIG_DWELL,
        ST_CLK_STB,
        ST_CLK_ACK,
        ST_CLK_DWELL,
        ST_TX_STB,
        ST_TX_ACK,
        ST_RX_STB,
        ST_RX_ACK,
        ST_SYN_DWELL,
        ST_RF_DWELL,
        ST_BF_STB,
        ST_BF_ACK,
        ST_PA_DWELL,
        ST_PA_STB,
        ST_PA_ACK,
        ST_UP,
        ST_DN_PA_DWELL,
        ST_DN_RF
    } step_e;

endpackage

// File: rtl/pwrseq_ms_prescaler.sv
module pwrseq_ms_prescaler #(
    parameter int CLKS_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;

    generate
        if (CLKS_PER_MS <= 1) begin : g_passthru
            assign tick = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_d, cnt_q;
            localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_MS - 1);

            assign tick = (cnt_q == LAST);

            always_comb begin
                cnt_d = cnt_q + 1'b1;
                if (clear || tick) cnt_d = '0;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate

endmodule

// File: rtl/pwrseq_dwell_timer.sv
module pwrseq_dwell_timer #(
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    input  logic            ms_tick,
    output logic            expired
);
    logic [MS_W-1:0] left_d, left_q;

    assign expired = (left_q == '0);

    always_comb begin
        left_d = left_q;
        if (load)                      left_d = load_ms;
        else if (ms_tick && !expired)  left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

endmodule

// File: rtl/pwrseq_out_decode.sv
module pwrseq_out_decode
    import pwrseq_pkg::*;
#(
    parameter bit EXTENDED = 1'b1
) (
    input  step_e  step,
    output logic   dig_en,
    output logic   rf_en,
    output logic   pa_en,
    output logic   clk_stb,
    output logic   tx_stb,
    output logic   rx_stb,
    output logic   bf_stb,
    output logic   pa_stb,
    output stage_e stage
);
    always_comb begin
        dig_en  = (step != ST_IDLE);
        rf_en   = step inside {ST_RF_DWELL, ST_BF_STB, ST_BF_ACK, ST_PA_DWELL,
                               ST_PA_STB, ST_PA_ACK, ST_UP, ST_DN_PA_DWELL};
        pa_en   = (step inside {ST_PA_DWELL, ST_PA_STB, ST_PA_ACK}) ||
                  (step == ST_UP && EXTENDED);
        clk_stb = (step == ST_CLK_STB);
        tx_stb  = (step == ST_TX_STB);
        rx_stb  = (step == ST_RX_STB);
        bf_stb  = (step == ST_BF_STB);
        pa_stb  = (step == ST_PA_STB);
        unique case (step)
            ST_IDLE:                                      stage = STG_OFF;
            ST_DIG_DWELL, ST_CLK_STB, ST_CLK_ACK,
            ST_CLK_DWELL:                                 stage = STG_DIGITAL;
            ST_TX_STB, ST_TX_ACK, ST_RX_STB, ST_RX_ACK,
            ST_SYN_DWELL:                                 stage = STG_SYNTH;
            ST_RF_DWELL, ST_BF_STB, ST_BF_ACK, ST_DN_RF:  stage = STG_RF;
            ST_PA_DWELL, ST_PA_STB, ST_PA_ACK,
            ST_DN_PA_DWELL:                               stage = STG_PA;
            ST_UP:                                        stage = STG_READY;
            default:                                      stage = STG_OFF;
        endcase
    end

endmodule

// File: rtl/rf_power_sequencer.sv
module rf_power_sequencer
    import pwrseq_pkg::*;
#(
    parameter bit EXTENDED    = 1'b1,
    parameter int CLKS_PER_MS = 50000,
    parameter int NUM_BF      = 4,
    parameter int DIG_MS      = 50,
    parameter int CLK_MS      = 10,
    parameter int SYN_MS      = 20,
    parameter int RF_MS       = 30,
    parameter int PA_MS       = 100,
    parameter int PA_DN_MS    = 50,
    localparam int BF_W       = (NUM_BF > 1) ? $clog2(NUM_BF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            power_up,
    input  logic            power_down,
    input  logic            init_done,
    output logic            dig_rail_en,
    output logic            rf_rail_en,
    output logic            pa_rail_en,
    output logic            clkgen_init,
    output logic            synth_tx_init,
    output logic            synth_rx_init,
    output logic            bf_init,
    output logic [BF_W-1:0] bf_sel,
    output logic            pa_bias_init,
    output logic [2:0]      stage,
    output logic            ready,
    output logic            off
);
    localparam int MAX_A  = (DIG_MS > CLK_MS) ? DIG_MS : CLK_MS;
    localparam int MAX_B  = (SYN_MS > RF_MS) ? SYN_MS : RF_MS;
    localparam int MAX_C  = (PA_MS > PA_DN_MS) ? PA_MS : PA_DN_MS;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_MS = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int MS_W   = $clog2(MAX_MS + 1);
    localparam logic [BF_W-1:0] BF_LAST = BF_W'(NUM_BF - 1);

    typedef struct packed {
        step_e           step;
        logic [BF_W-1:0] bf;
    } fsm_t;

    fsm_t            fsm_d, fsm_q;
    logic            tmr_load;
    logic [MS_W-1:0] tmr_ms;
    logic            ms_tick;
    logic            expired;
    logic            pa_live;
    logic            tearing;
    stage_e          stage_w;

    pwrseq_ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_load),
        .tick  (ms_tick)
    );

    pwrseq_dwell_timer #(.MS_W(MS_W)) u_dwell (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_ms (tmr_ms),
        .ms_tick (ms_tick),
        .expired (expired)
    );

    always_comb begin
        fsm_d    = fsm_q;
        tmr_load = 1'b0;
        tmr_ms   = '0;
        pa_live  = (fsm_q.step inside {ST_PA_DWELL, ST_PA_STB, ST_PA_ACK}) ||
                   (fsm_q.step == ST_UP && EXTENDED);
        tearing  = fsm_q.step inside {ST_IDLE, ST_DN_PA_DWELL, ST_DN_RF};
        if (power_down && !tearing) begin
            if (pa_live) begin
                fsm_d.step = ST_DN_PA_DWELL;
                tmr_load   = 1'b1;
                tmr_ms     = MS_W'(PA_DN_MS);
            end else begin
                fsm_d.step = ST_DN_RF;
            end
        end else begin
            unique case (fsm_q.step)
                ST_IDLE: if (power_up) begin
                    fsm_d.step = ST_DIG_DWELL;
                    tmr_load   = 1'b1;
                    tmr_ms     = MS_W'(DIG_MS);
                end
                ST_DIG_DWELL: if (expired) fsm_d.step = ST_CLK_STB;
                ST_CLK_STB:   fsm_d.step = ST_CLK_ACK;
                ST_CLK_ACK: if (init_done) begin
                    fsm_d.step = ST_CLK_DWELL;
                    tmr_load   = 1'b1;
                    tmr_ms     = MS_W'(CLK_MS);
                end
                ST_CLK_DWELL: if (expired) fsm_d.step = ST_TX_STB;
                ST_TX_STB:    fsm_d.step = ST_TX_ACK;
                ST_TX_ACK:    if (init_done) fsm_d.step = ST_RX_STB;
                ST_RX_STB:    fsm_d.step = ST_RX_ACK;
                ST_RX_ACK: if (init_done) begin
                    fsm_d.step = ST_SYN_DWELL;
                    tmr_load   = 1'b1;
                    tmr_ms     = MS_W'(SYN_MS);
                end
                ST_SYN_DWELL: if (expired) begin
                    fsm_d.step = ST_RF_DWELL;
                    tmr_load   = 1'b1;
                    tmr_ms     = MS_W'(RF_MS);
                end
                ST_RF_DWELL: if (expired) begin
                    fsm_d.step = ST_BF_STB;
                    fsm_d.bf   = '0;
                end
                ST_BF_STB:    fsm_d.step = ST_BF_ACK;
                ST_BF_ACK: if (init_done) begin
                    if (fsm_q.bf != BF_LAST) begin
                        fsm_d.bf   = fsm_q.bf + 1'b1;
                        fsm_d.step = ST_BF_STB;
                    end else if (EXTENDED) begin
                        fsm_d.step = ST_PA_DWELL;
                        tmr_load   = 1'b1;
                        tmr_ms     = MS_W'(PA_MS);
                    end else begin
                        fsm_d.step = ST_UP;
                    end
                end
                ST_PA_DWELL:  if (expired) fsm_d.step = ST_PA_STB;
                ST_PA_STB:    fsm_d.step = ST_PA_ACK;
                ST_PA_ACK:    if (init_done) fsm_d.step = ST_UP;
                ST_UP:        fsm_d.step = ST_UP;
                ST_DN_PA_DWELL: if (expired) fsm_d.step = ST_DN_RF;
                ST_DN_RF:     fsm_d.step = ST_IDLE;
                default:      fsm_d.step = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.step <= ST_IDLE;
            fsm_q.bf   <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    pwrseq_out_decode #(.EXTENDED(EXTENDED)) u_decode (
        .step    (fsm_q.step),
        .dig_en  (dig_rail_en),
        .rf_en   (rf_rail_en),
        .pa_en   (pa_rail_en),
        .clk_stb (clkgen_init),
        .tx_stb  (synth_tx_init),
        .rx_stb  (synth_rx_init),
        .bf_stb  (bf_init),
        .pa_stb  (pa_bias_init),
        .stage   (stage_w)
    );

    assign bf_sel = fsm_q.bf;
    assign stage  = stage_w;
    assign ready  = (stage_w == STG_READY);
    assign off    = (stage_w == STG_OFF);

endmodule

// File: rtl/rf_power_sequencer_checker.sv
module rf_power_sequencer_checker #(
    parameter bit EXTENDED = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic power_up,
    input logic power_down,
    input logic dig_rail_en,
    input logic rf_rail_en,
    input logic pa_rail_en,
    input logic clkgen_init,
    input logic synth_tx_init,
    input logic synth_rx_init,
    input logic bf_init,
    input logic pa_bias_init,
    input logic ready,
    input logic off
);
    logic any_stb;
    assign any_stb = clkgen_init | synth_tx_init | synth_rx_init | bf_init | pa_bias_init;

    assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clkgen_init, synth_tx_init, synth_rx_init, bf_init, pa_bias_init}));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

    assert_up_digital_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (off && power_up) |=> (dig_rail_en && !rf_rail_en));

    assert_rf_under_dig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rail_en |-> dig_rail_en);

    assert_pa_under_rf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pa_rail_en |-> (rf_rail_en && EXTENDED));

    assert_ready_rails_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (dig_rail_en && rf_rail_en && (pa_rail_en || !EXTENDED)));

    assert_dig_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_rail_en) |-> (!rf_rail_en && !$past(rf_rail_en) && off));

    assert_off_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (off && !power_up) |=> off);

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && power_down) |=> (!ready && !any_stb));

endmodule

bind rf_power_sequencer rf_power_sequencer_checker #(.EXTENDED(EXTENDED)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .power_up      (power_up),
    .power_down    (power_down),
    .dig_rail_en   (dig_rail_en),
    .rf_rail_en    (rf_rail_en),
    .pa_rail_en    (pa_rail_en),
    .clkgen_init   (clkgen_init),
    .synth_tx_init (synth_tx_init),
    .synth_rx_init (synth_rx_init),
    .bf_init       (bf_init),
    .pa_bias_init  (pa_bias_init),
    .ready         (ready),
    .off           (off)
);

// File: tb/rf_power_sequencer_bench.sv
module pwrseq_ref_model #(
    parameter bit EXT = 1'b1,
    parameter int P   = 4,
    parameter int NBF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic up,
    input  logic down,
    input  logic done,
    output logic exp_dig,
    output logic exp_rf,
    output logic exp_pa,
    output int   exp_stb,
    output int   exp_bf,
    output int   exp_stage
);
    typedef struct {
        int len; bit ack; bit dig; bit rf; bit pa;
        int stb; int bf; int stage; bit dn; bit hold;
    } ent_t;

    ent_t q[$];
    int   cnt;

    function automatic void add(int len, bit ack, bit d, bit r, bit p,
                                int stb, int bf, int stg, bit dn, bit hold);
        ent_t e;
        e.len = len; e.ack = ack; e.dig = d; e.rf = r; e.pa = p;
        e.stb = stb; e.bf = bf; e.stage = stg; e.dn = dn; e.hold = hold;
        q.push_back(e);
    endfunction

    function automatic void plan_up();
        add(50*P+1, 0, 1, 0, 0, 0, 0, 1, 0, 0);
        add(1, 0, 1, 0, 0, 1, 0, 1, 0, 0);
        add(0, 1, 1, 0, 0, 0, 0, 1, 0, 0);
        add(10*P+1, 0, 1, 0, 0, 0, 0, 1, 0, 0);
        add(1, 0, 1, 0, 0, 2, 0, 2, 0, 0);
        add(0, 1, 1, 0, 0, 0, 0, 2, 0, 0);
        add(1, 0, 1, 0, 0, 3, 0, 2, 0, 0);
        add(0, 1, 1, 0, 0, 0, 0, 2, 0, 0);
        add(20*P+1, 0, 1, 0, 0, 0, 0, 2, 0, 0);
        add(30*P+1, 0, 1, 1, 0, 0, 0, 3, 0, 0);
        for (int i = 0; i < NBF; i++) begin
            add(1, 0, 1, 1, 0, 4, i, 3, 0, 0);
            add(0, 1, 1, 1, 0, 0, i, 3, 0, 0);
        end
        if (EXT) begin
            add(100*P+1, 0, 1, 1, 1, 0, 0, 4, 0, 0);
            add(1, 0, 1, 1, 1, 5, 0, 4, 0, 0);
            add(0, 1, 1, 1, 1, 0, 0, 4, 0, 0);
        end
        add(0, 0, 1, 1, EXT, 0, 0, 5, 0, 1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete();
            cnt = 0;
        end else begin
            if (q.size() == 0) begin
                if (up) begin plan_up(); cnt = 0; end
            end else if (down && !q[0].dn) begin
                bit pa_on;
                pa_on = q[0].pa;
                q.delete();
                cnt = 0;
                if (pa_on) add(50*P+1, 0, 1, 1, 0, 0, 0, 4, 1, 0);
                add(1, 0, 1, 0, 0, 0, 0, 3, 1, 0);
            end else if (!q[0].hold) begin
                if (q[0].ack) begin
                    if (done) begin void'(q.pop_front()); cnt = 0; end
                end else begin
                    cnt++;
                    if (cnt >= q[0].len) begin void'(q.pop_front()); cnt = 0; end
                end
            end
        end
        if (q.size() == 0) begin
            exp_dig = 0; exp_rf = 0; exp_pa = 0; exp_stb = 0; exp_bf = -1; exp_stage = 0;
        end else begin
            exp_dig = q[0].dig; exp_rf = q[0].rf; exp_pa = q[0].pa;
            exp_stb = q[0].stb; exp_bf = q[0].bf; exp_stage = q[0].stage;
        end
    end
endmodule

module rf_power_sequencer_bench;
    localparam int P = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic pwr_up = 0, pwr_down = 0;
    logic done_e, done_b;
    logic stray = 0, hold_e = 0;
    int   lat = 1;
    int   checks = 0, errors = 0, cycles = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    logic       dig_e, rf_e, pa_e, ck_e, tx_e, rx_e, bf_e, pb_e, rdy_e, off_e;
    logic [1:0] sel_e;
    logic [2:0] stg_e;
    logic       dig_b, rf_b, pa_b, ck_b, tx_b, rx_b, bf_b, pb_b, rdy_b, off_b;
    logic [1:0] sel_b;
    logic [2:0] stg_b;

    rf_power_sequencer #(.EXTENDED(1'b1), .CLKS_PER_MS(P)) u_rf_power_sequencer (
        .clk(clk), .rst_n(rst_n), .power_up(pwr_up), .power_down(pwr_down),
        .init_done(done_e), .dig_rail_en(dig_e), .rf_rail_en(rf_e), .pa_rail_en(pa_e),
        .clkgen_init(ck_e), .synth_tx_init(tx_e), .synth_rx_init(rx_e), .bf_init(bf_e),
        .bf_sel(sel_e), .pa_bias_init(pb_e), .stage(stg_e), .ready(rdy_e), .off(off_e));

    rf_power_sequencer #(.EXTENDED(1'b0), .CLKS_PER_MS(P)) u_rf_power_sequencer_base (
        .clk(clk), .rst_n(rst_n), .power_up(pwr_up), .power_down(pwr_down),
        .init_done(done_b), .dig_rail_en(dig_b), .rf_rail_en(rf_b), .pa_rail_en(pa_b),
        .clkgen_init(ck_b), .synth_tx_init(tx_b), .synth_rx_init(rx_b), .bf_init(bf_b),
        .bf_sel(sel_b), .pa_bias_init(pb_b), .stage(stg_b), .ready(rdy_b), .off(off_b));

    logic m_dig_e, m_rf_e, m_pa_e, m_dig_b, m_rf_b, m_pa_b;
    int   m_stb_e, m_bf_e, m_stg_e, m_stb_b, m_bf_b, m_stg_b;

    pwrseq_ref_model #(.EXT(1'b1), .P(P)) u_model_e (
        .clk(clk), .rst_n(rst_n), .up(pwr_up), .down(pwr_down), .done(done_e),
        .exp_dig(m_dig_e), .exp_rf(m_rf_e), .exp_pa(m_pa_e),
        .exp_stb(m_stb_e), .exp_bf(m_bf_e), .exp_stage(m_stg_e));

    pwrseq_ref_model #(.EXT(1'b0), .P(P)) u_model_b (
        .clk(clk), .rst_n(rst_n), .up(pwr_up), .down(pwr_down), .done(done_b),
        .exp_dig(m_dig_b), .exp_rf(m_rf_b), .exp_pa(m_pa_b),
        .exp_stb(m_stb_b), .exp_bf(m_bf_b), .exp_stage(m_stg_b));

    function automatic int stb_code(logic c, logic t, logic r, logic b, logic p);
        int n;
        n = int'(c) + int'(t) + int'(r) + int'(b) + int'(p);
        if (n > 1) return 7;
        if (c) return 1;
        if (t) return 2;
        if (r) return 3;
        if (b) return 4;
        if (p) return 5;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
        end
    endtask

    // acknowledge responders: done one or more cycles after each strobe
    int pend_e = 0, pend_b = 0;
    logic resp_e = 0, resp_b = 0;
    assign done_e = resp_e | stray;
    assign done_b = resp_b | stray;

    always @(negedge clk) begin
        resp_e <= 0;
        if (stb_code(ck_e, tx_e, rx_e, bf_e, pb_e) != 0) pend_e = hold_e ? 0 : lat + 1;
        else if (pend_e > 0) begin pend_e--; if (pend_e == 0) resp_e <= 1; end
        resp_b <= 0;
        if (stb_code(ck_b, tx_b, rx_b, bf_b, pb_b) != 0) pend_b = lat + 1;
        else if (pend_b > 0) begin pend_b--; if (pend_b == 0) resp_b <= 1; end
    end

    // per-cycle comparison against the models
    int seq_e[$];
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int se, sb;
            cycles++;
            se = stb_code(ck_e, tx_e, rx_e, bf_e, pb_e);
            sb = stb_code(ck_b, tx_b, rx_b, bf_b, pb_b);
            if (se != 0) seq_e.push_back(se);
            check("R3 ext dig rail", dig_e, m_dig_e);
            check("R6 ext rf rail", rf_e, m_rf_e);
            check("R7 ext pa rail", pa_e, m_pa_e);
            check("R4 ext strobe", se, m_stb_e);
            if (bf_e) check("R6 ext bf_sel", sel_e, m_bf_e);
            check("R2 ext stage", stg_e, m_stg_e);
            check("R8 ext ready", rdy_e, m_stg_e == 5);
            check("R8 ext off", off_e, m_stg_e == 0);
            check("R3 base dig rail", dig_b, m_dig_b);
            check("R6 base rf rail", rf_b, m_rf_b);
            check("R7 base pa rail", pa_b, m_pa_b);
            check("R4 base strobe", sb, m_stb_b);
            if (bf_b) check("R6 base bf_sel", sel_b, m_bf_b);
            check("R2 base stage", stg_b, m_stg_b);
            check("R8 base ready", rdy_b, m_stg_b == 5);
        end
    end

    task automatic pulse_up();
        @(negedge clk); pwr_up = 1; @(negedge clk); pwr_up = 0;
    endtask
    task automatic pulse_down();
        @(negedge clk); pwr_down = 1; @(negedge clk); pwr_down = 0;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int t_pa, t_rf, t_dig;
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin
        int gap, gap2;
        idle(3);
        // R1: reset state
        check("R1 dig off in reset", dig_e, 0);
        check("R1 stage in reset", stg_e, 0);
        check("R1 off in reset", off_e, 1);
        check("R1 no strobe in reset", stb_code(ck_e, tx_e, rx_e, bf_e, pb_e), 0);
        rst_n = 1;
        idle(2);
        check("R1 off after reset", off_e, 1);
        // R10: power_down while off ignored
        pulse_down();
        idle(3);
        check("R10 down ignored when off", off_e, 1);

        // full power-up, latency 1, stray done during digital dwell (R4)
        lat = 1;
        seq_e.delete();
        pulse_up();
        check("R3 dig rail after request", dig_e, 1);
        idle(20);
        @(negedge clk); stray = 1; @(negedge clk); stray = 0;
        check("R4 stray done ignored, stage", stg_e, 1);
        pulse_up(); // R10: ignored mid-sequence
        while (!rdy_b) @(negedge clk);
        check("R7 base pa rail stays off", pa_b, 0);
        check("R8 ext not yet ready", rdy_e, 0);
        while (!rdy_e) @(negedge clk);
        check("R8 ext ready rails", {dig_e, rf_e, pa_e}, 3'b111);
        check("R5 strobe order length", seq_e.size(), 8);
        if (seq_e.size() == 8) begin
            check("R5 order clk", seq_e[0], 1);
            check("R5 order tx", seq_e[1], 2);
            check("R5 order rx", seq_e[2], 3);
            check("R6 order bf", seq_e[6], 4);
            check("R7 order pa bias last", seq_e[7], 5);
        end
        pulse_up();
        idle(3);
        check("R10 up ignored when ready", stg_e, 5);

        // R9: shutdown order and dwell
        @(negedge clk); pwr_down = 1; @(negedge clk); pwr_down = 0;
        check("R9 pa dropped first", pa_e, 0);
        check("R9 rf still on", rf_e, 1);
        check("R9 base rf drop stage", stg_b, 3);
        gap = 1;
        while (rf_e) begin @(negedge clk); gap++; end
        check("R9 pa to rf gap", gap, 50*P + 1 + 1);
        check("R9 dig still on after rf drop", dig_e, 1);
        @(negedge clk);
        check("R9 dig drops next", dig_e, 0);
        check("R9 back to off", off_e, 1);

        // R11: abort during synthesizer ack wait, latency 3
        lat = 3;
        pulse_up();
        while (!(tx_e)) @(negedge clk);
        @(negedge clk);
        @(negedge clk); pwr_down = 1; @(negedge clk); pwr_down = 0;
        check("R11 abort to rf drop stage", stg_e, 3);
        check("R11 abort rf off", rf_e, 0);
        @(negedge clk);
        check("R11 abort reaches off", off_e, 1);

        // R11: abort during amplifier dwell, latency 0
        lat = 0;
        pulse_up();
        while (stg_e != 4) @(negedge clk);
        idle(30);
        @(negedge clk); pwr_down = 1; @(negedge clk); pwr_down = 0;
        check("R11 abort in pa dwell drops pa", pa_e, 0);
        check("R11 abort in pa dwell keeps rf", rf_e, 1);
        check("R11 abort in pa dwell stage", stg_e, 4);
        while (!off_e) @(negedge clk);
        while (!off_b) @(negedge clk);

        // R12: missing acknowledge stalls
        lat = 2;
        hold_e = 1;
        pulse_up();
        while (!ck_e) @(negedge clk);
        idle(600);
        check("R12 stalled stage", stg_e, 1);
        check("R12 stalled rails", {dig_e, rf_e}, 2'b10);
        check("R12 no further strobe", stb_code(ck_e, tx_e, rx_e, bf_e, pb_e), 0);
        hold_e = 0;
        while (!rdy_b) @(negedge clk);
        @(negedge clk); stray = 1; @(negedge clk); stray = 0;
        while (!tx_e) @(negedge clk);
        check("R12 resumes after late done", stg_e, 2);
        while (!rdy_e) @(negedge clk);
        pulse_down();
        while (!off_e) @(negedge clk);
        idle(5);
        check("R10 down-sequence ends off", off_b, 1);
        finish_run();
    end
endmodule